// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Force

This block turns timing events from a PWM time base into two output waveforms, A and B. Each cycle it may receive up to four event strobes: counter at zero, counter at period, counter matching compare A while counting up, and counter matching compare B while counting up. Each output has its own action register. Each event has a 2-bit field in it that says whether that event clears the output, sets it, toggles it or leaves it alone. The time-base counter and the comparators sit outside the block and supply the strobes.

Software can pin either output to a fixed level with a continuous force code. Force codes are written into a shadow copy. The shadow is copied into the active copy at a selectable point: counter zero, counter period, either of these, or at once. This allows a force to be applied or released in step with the PWM cycle. While a force is active it beats every event action. The output register takes the forced level, so the output stays at that level after release until the next event acts on it. All configuration arrives on a single-cycle write port.

Top module: `pwm_aq_force`

## Requirements
- R1: After reset both outputs are low, all action fields are 00, the force shadow and active copies are 00 and the reload mode is 00. With no writes, events do not change the outputs.
- R2: An action code of 00 leaves the output unchanged, 01 drives it low, 10 drives it high and 11 inverts it. The output changes after the clock edge that samples the event.
- R3: Write address 0 holds the action register of output A and address 1 holds that of output B. In each, bits 1:0 are the zero action, bits 3:2 the period action, bits 5:4 the compare-A up action and bits 9:8 the compare-B up action. Either compare event acts on either output through its own field.
- R4: When several events arrive in the same cycle, the action applied is that of the highest-priority event whose field is not 00. The order is compare-B, then compare-A, then period, then zero.
- R5: Write address 3 holds the force shadow, with bits 1:0 for output A and bits 3:2 for output B. Code 01 forces low, 10 forces high, and 00 and 11 both mean no force.
- R6: While an output's active force code is 01 or 10, the output shows the forced level whatever events arrive. After the force is released, the output keeps that level until an event action changes it.
- R7: Bits 7:6 at write address 2 choose when the force shadow is copied to the active copy: 00 on a zero event, 01 on a period event, 10 on either event, 11 in every cycle. A shadow change has no effect on the outputs until the copy takes place.
- R8: In mode 11, a force write affects the output right after the clock edge that captures the write.
- R9: If a force write falls in the same cycle as a copy point, the active copy takes the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Time-base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 16 | Write data |
| ev_zero_i | input | 1 | Counter reached zero |
| ev_prd_i | input | 1 | Counter reached period |
| ev_cmpa_up_i | input | 1 | Counter matched compare A while counting up |
| ev_cmpb_up_i | input | 1 | Counter matched compare B while counting up |
| pwm_a_o | output | 1 | Output A |
| pwm_b_o | output | 1 | Output B |

## Verification
Two kinds of collision can land in the same cycle. One is several event strobes together, which the priority order must resolve. The other is a force write arriving on the very cycle its copy point fires. The bench provokes the first with directed strobe bundles whose fields disagree, and the second by pairing a force write with a zero strobe. It then runs many cycles of random strobes and random writes to all four addresses. A cycle-level model built from the requirements predicts both outputs after every edge and judges each one.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned ACT_W    = 2;
  localparam int unsigned CFG_W    = 4 * ACT_W;
  localparam int unsigned FRC_W    = NUM_CH * ACT_W;
  localparam int unsigned ADDR_RLD = 2;
  localparam int unsigned ADDR_FRC = 3;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO = 2'b00,
    RLD_PRD  = 2'b01,
    RLD_BOTH = 2'b10,
    RLD_NOW  = 2'b11
  } rld_e;

  typedef struct packed {
    logic cmpb;
    logic cmpa;
    logic prd;
    logic zero;
  } evt_t;

  function automatic logic frc_is_on(input logic [1:0] code);
    return (code == 2'b01) || (code == 2'b10);
  endfunction

  function automatic logic frc_level(input logic [1:0] code);
    return code == 2'b10;
  endfunction
endpackage

// File: rtl/aq_regs.sv
module aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [NUM_CH-1:0][CFG_W-1:0]   act_cfg_o,
  output rld_e                           rld_mode_o,
  output logic                           frc_wr_o,
  output logic [FRC_W-1:0]               frc_data_o
);
  logic unused_hi;
  assign unused_hi = ^wr_data_i[DATA_W-1:10];

  // action fields packed as {cmpb, cmpa, prd, zero}
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_act
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_cfg_o[ch] <= '0;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(ch)) begin
        act_cfg_o[ch] <= {wr_data_i[9:8], wr_data_i[5:4], wr_data_i[3:2], wr_data_i[1:0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_mode_o <= RLD_ZERO;
    end else if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_RLD)) begin
      rld_mode_o <= rld_e'(wr_data_i[7:6]);
    end
  end

  assign frc_wr_o   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_FRC));
  assign frc_data_o = wr_data_i[FRC_W-1:0];
endmodule

// File: rtl/aq_force.sv
module aq_force
  import pwm_aq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rld_e             rld_mode_i,
  input  logic             ev_zero_i,
  input  logic             ev_prd_i,
  input  logic             frc_wr_i,
  input  logic [FRC_W-1:0] frc_data_i,
  output logic [FRC_W-1:0] frc_act_o
);
  logic [FRC_W-1:0] shadow_q;
  logic             reload;

  always_comb begin
    unique case (rld_mode_i)
      RLD_ZERO: reload = ev_zero_i;
      RLD_PRD:  reload = ev_prd_i;
      RLD_BOTH: reload = ev_zero_i | ev_prd_i;
      default:  reload = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (frc_wr_i) begin
      shadow_q <= frc_data_i;
    end
  end

  // a write coinciding with the copy point is forwarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frc_act_o <= '0;
    end else if (reload) begin
      frc_act_o <= frc_wr_i ? frc_data_i : shadow_q;
    end
  end

  AST_SHADOW_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_mode_i != RLD_NOW && !ev_zero_i && !ev_prd_i) |=> $stable(frc_act_o)); // R7
  AST_IMMEDIATE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_mode_i == RLD_NOW && frc_wr_i) |=> (frc_act_o == $past(frc_data_i))); // R8
endmodule

// File: rtl/aq_channel.sv
module aq_channel
  import pwm_aq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  evt_t             ev_i,
  input  logic [1:0]       frc_i,
  output logic             out_o
);
  logic out_q;
  logic frc_en;
  logic frc_hi;
  act_e act;

  assign frc_en = frc_is_on(frc_i);
  assign frc_hi = frc_level(frc_i);

  // ascending priority: later assignment wins
  always_comb begin
    act = ACT_NONE;
    if (ev_i.zero && cfg_i[1:0] != 2'b00) act = act_e'(cfg_i[1:0]);
    if (ev_i.prd  && cfg_i[3:2] != 2'b00) act = act_e'(cfg_i[3:2]);
    if (ev_i.cmpa && cfg_i[5:4] != 2'b00) act = act_e'(cfg_i[5:4]);
    if (ev_i.cmpb && cfg_i[7:6] != 2'b00) act = act_e'(cfg_i[7:6]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
    end else if (frc_en) begin
      out_q <= frc_hi;
    end else begin
      unique case (act)
        ACT_LOW:  out_q <= 1'b0;
        ACT_HIGH: out_q <= 1'b1;
        ACT_TOG:  out_q <= ~out_q;
        default:  out_q <= out_q;
      endcase
    end
  end

  assign out_o = frc_en ? frc_hi : out_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frc_en && ev_i == '0) |=> (out_q == $past(out_q))); // R2
  AST_FORCE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_en |=> (out_q == $past(frc_hi))); // R6
endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
  import pwm_aq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ev_zero_i,
  input  logic              ev_prd_i,
  input  logic              ev_cmpa_up_i,
  input  logic              ev_cmpb_up_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o
);
  logic [NUM_CH-1:0][CFG_W-1:0] act_cfg;
  rld_e                         rld_mode;
  logic                         frc_wr;
  logic [FRC_W-1:0]             frc_data;
  logic [FRC_W-1:0]             frc_act;
  logic [NUM_CH-1:0]            pwm_out;
  evt_t                         ev;

  assign ev = '{cmpb: ev_cmpb_up_i, cmpa: ev_cmpa_up_i, prd: ev_prd_i, zero: ev_zero_i};

  aq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .act_cfg_o  (act_cfg),
    .rld_mode_o (rld_mode),
    .frc_wr_o   (frc_wr),
    .frc_data_o (frc_data)
  );

  aq_force u_force (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rld_mode_i (rld_mode),
    .ev_zero_i  (ev_zero_i),
    .ev_prd_i   (ev_prd_i),
    .frc_wr_i   (frc_wr),
    .frc_data_i (frc_data),
    .frc_act_o  (frc_act)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    aq_channel u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (act_cfg[ch]),
      .ev_i   (ev),
      .frc_i  (frc_act[ACT_W*ch +: ACT_W]),
      .out_o  (pwm_out[ch])
    );
  end

  assign pwm_a_o = pwm_out[0];
  assign pwm_b_o = pwm_out[1];

  AST_FORCE_LOW_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_act[1:0] == 2'b01) |-> !pwm_a_o); // R5
  AST_FORCE_HIGH_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_act[3:2] == 2'b10) |-> pwm_b_o); // R5
endmodule

// File: tb/pwm_aq_force_bench.sv
module pwm_aq_force_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  ev = '0; // {cmpb, cmpa, prd, zero}
  logic        pwm_a, pwm_b;

  int n_checks = 0;
  int n_fail = 0;

  logic [15:0] m_cfg [2];
  logic [1:0]  m_mode;
  logic [3:0]  m_shadow;
  logic [3:0]  m_active;
  logic        m_q [2];

  always #4 clk = ~clk;

  pwm_aq_force u_pwm_aq_force (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ev_zero_i(ev[0]), .ev_prd_i(ev[1]),
    .ev_cmpa_up_i(ev[2]), .ev_cmpb_up_i(ev[3]), .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
  );

  function automatic logic [1:0] pick(input logic [15:0] c, input logic [3:0] e);
    logic [1:0] a = 2'b00;
    if (e[0] && c[1:0] != 0) a = c[1:0];
    if (e[1] && c[3:2] != 0) a = c[3:2];
    if (e[2] && c[5:4] != 0) a = c[5:4];
    if (e[3] && c[9:8] != 0) a = c[9:8];
    return a;
  endfunction

  function automatic logic f_on(input logic [1:0] f);
    return f == 2'b01 || f == 2'b10;
  endfunction

  function automatic logic exp_out(input int ch);
    logic [1:0] f = m_active[2*ch +: 2];
    return f_on(f) ? (f == 2'b10) : m_q[ch];
  endfunction

  task automatic check(input string tag, input logic got, input logic exp, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cfg[0] = '0; m_cfg[1] = '0; m_mode = '0; m_shadow = '0; m_active = '0;
    m_q[0] = 1'b0; m_q[1] = 1'b0;
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d,
                     input logic [3:0] e, input string tag);
    logic rl;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; ev = e;
    for (int ch = 0; ch < 2; ch++) begin
      logic [1:0] f = m_active[2*ch +: 2];
      if (f_on(f)) m_q[ch] = (f == 2'b10);
      else case (pick(m_cfg[ch], e))
        2'b01: m_q[ch] = 1'b0;
        2'b10: m_q[ch] = 1'b1;
        2'b11: m_q[ch] = ~m_q[ch];
        default: ;
      endcase
    end
    rl = (m_mode == 2'b11) || (e[0] && (m_mode == 2'b00 || m_mode == 2'b10)) ||
         (e[1] && (m_mode == 2'b01 || m_mode == 2'b10));
    if (rl) m_active = (we && a == 2'd3) ? d[3:0] : m_shadow;
    if (we) case (a)
      2'd0: m_cfg[0] = d;
      2'd1: m_cfg[1] = d;
      2'd2: m_mode = d[7:6];
      default: m_shadow = d[3:0];
    endcase
    @(posedge clk);
    #1;
    check(tag, pwm_a, exp_out(0), "pwm_a");
    check(tag, pwm_b, exp_out(1), "pwm_b");
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
    cyc(1'b1, a, d, 4'b0000, tag);
  endtask

  task automatic evt(input logic [3:0] e, input string tag);
    cyc(1'b0, 2'd0, 16'h0, e, tag);
  endtask

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", pwm_a, 1'b0, "reset pwm_a");
    check("R1", pwm_b, 1'b0, "reset pwm_b");
    evt(4'b1111, "R1");
    evt(4'b0001, "R1");

    // R2: codes on the zero event for output A
    wr(2'd0, 16'h0002, "R2");
    evt(4'b0001, "R2");
    wr(2'd0, 16'h0001, "R2");
    evt(4'b0001, "R2");
    wr(2'd0, 16'h0003, "R2");
    evt(4'b0001, "R2");
    evt(4'b0001, "R2");
    wr(2'd0, 16'h0000, "R2");
    evt(4'b0001, "R2");

    // R3: field positions, compare-B acting on output A, compare-A on B
    wr(2'd0, 16'h0200, "R3");
    wr(2'd1, 16'h0020, "R3");
    evt(4'b1000, "R3");
    evt(4'b0100, "R3");
    wr(2'd1, 16'h0008, "R3");
    evt(4'b0010, "R3");

    // R4: conflicting events
    wr(2'd0, 16'h0261, "R4");  // cmpb=10 cmpa=10? -> 0x261: cmpb=10 cmpa=10 prd=00 zero=01
    wr(2'd0, 16'h0119, "R4");  // cmpb=01 cmpa=01 prd=10 zero=01
    evt(4'b0011, "R4");
    evt(4'b0111, "R4");
    wr(2'd0, 16'h0229, "R4");  // cmpb=10 cmpa=10 prd=10 zero=01
    evt(4'b0101, "R4");
    evt(4'b1111, "R4");
    wr(2'd0, 16'h0019, "R4");  // cmpb=00 -> cmpa wins
    evt(4'b1111, "R4");

    // R7/R5: shadow held until zero copy point
    wr(2'd0, 16'h0000, "R7");
    wr(2'd1, 16'h0000, "R7");
    wr(2'd3, 16'h0002, "R7");  // A force high
    evt(4'b0000, "R7");
    evt(4'b0010, "R7");        // period: no copy in mode 00
    evt(4'b0001, "R5");        // zero copies
    wr(2'd3, 16'h0003, "R5");  // code 11 = no force
    evt(4'b0001, "R5");
    wr(2'd2, 16'h0040, "R7");  // copy on period
    wr(2'd3, 16'h0004, "R7");  // B force low
    evt(4'b0001, "R7");
    evt(4'b0010, "R7");

    // R6: force beats events, level held after release
    wr(2'd1, 16'h022A, "R6");
    evt(4'b1111, "R6");
    wr(2'd1, 16'h0000, "R6");
    wr(2'd3, 16'h0000, "R6");
    evt(4'b0010, "R6");        // release
    evt(4'b0001, "R6");
    wr(2'd1, 16'h0002, "R6");
    evt(4'b0001, "R6");

    // R8: immediate mode
    wr(2'd2, 16'h00C0, "R8");
    wr(2'd3, 16'h0009, "R8");
    wr(2'd3, 16'h0000, "R8");

    // R9: write in the copy cycle
    wr(2'd2, 16'h0080, "R9");
    cyc(1'b1, 2'd3, 16'h0006, 4'b0001, "R9");
    cyc(1'b1, 2'd3, 16'h0000, 4'b0010, "R9");

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic we = ($urandom % 4) == 0;
      logic [1:0] a = 2'($urandom);
      logic [15:0] d = 16'($urandom);
      logic [3:0] e = 4'($urandom);
      cyc(we, a, d, e, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule